// File: doc/BRIEF.md
# Multi-Channel Match Timer with Snapshot Capture

This block holds several independent up-counters, one per channel, each paired with a small set of match comparators. A counter runs in its own counter clock domain and steps once per selected tick. The tick is either every counter clock or one of three external tick strobes that are synchronous to the counter clock. When a counter reaches the value held in one of its match registers, a sticky status bit is raised on the bus side. Any status bit whose enable is set drives the channel's level-sensitive, active-high interrupt.

Software never reads a live counter. It writes the channel's capture register, which starts a request/acknowledge handshake across the two clock domains. The counter domain latches the count and returns an acknowledge. A capture-status bit then reports that the snapshot is stable, and the value is read back from the capture address.

A channel can also run in preload mode. In that mode, when the counter sits on a chosen comparator's target and a tick arrives, it jumps to a programmed preload value instead of incrementing. This gives a repeating period.

Top module: `mct_timer`

## Requirements
- R1: After reset every writable register reads zero, every irq bit is low, each capture value reads zero and each capture-status register (offset 9) reads 1 in bit 0.
- R2: Bit c of the global enable register (global offset 0) enables channel c. While the bit is set, the counter increases by exactly one for each selected tick.
- R3: While its enable bit is clear, a channel's counter holds its value whatever the ticks do.
- R4: A write of any data to a channel's capture offset 8 clears bit 0 of that channel's capture-status register (offset 9) on the next bus cycle. Once the snapshot is stable the bit returns to 1, and offset 8 then reads the count as it was after the last tick before the request.
- R5: The 2-bit field at bits [2c+1:2c] of global offset 1 picks channel c's tick: 0 means every counter clock, and values 1, 2 and 3 mean ext_tick[0], ext_tick[1] and ext_tick[2]. Ticks on sources that are not selected leave the counter unchanged.
- R6: Without a reload, a counter at all ones goes to zero on its next tick.
- R7: Status bit k of a channel (offset 7, bit k) becomes 1 when its counter advances to the value in match register k (offset k, k = 0..NUM_CMP-1).
- R8: A status bit stays at 1 until it is cleared, whether or not its interrupt enable is set and whatever the counter does afterwards.
- R9: Writing offset 7 clears each status bit whose data bit is 1 and leaves the others alone. A match in the same cycle as a clear leaves the bit set.
- R10: irq[c] is high exactly when some status bit of channel c is 1 and its bit in the interrupt-enable register (offset 6) is also 1.
- R11: When bit c of global offset 2 is 0 and the preload control (offset 5) holds k+1, a tick that arrives while the counter equals match register k loads the preload value (offset 4) instead of incrementing. With the mode bit at 1 or the control at 0, there is no reload.
- R12: Channel c's registers sit at address c*16 + offset and the global registers at NUM_CH*16 + offset. Reads return data on the bus cycle after rd_en, with unused bits and unmapped offsets reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| cnt_clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| ext_tick | input | 3 | External tick strobes, synchronous to cnt_clk |
| irq | output | NUM_CH | Per-channel interrupt, level, active high |

## Verification
The bench uses an 8-bit counter so that the whole count range can be walked. It sweeps bursts of ticks of increasing length on a shared source and compares every snapshot with an arithmetic model. This separates correct stepping from dropped or doubled ticks. Ticks on a source that is not selected, and ticks while the channel is disabled, separate the source decode and the enable gating from the counting itself. A tick-by-tick walk through three match targets checks after each step both the status bits and the interrupt, which tells a sticky bit apart from a level compare. A full walk to wrap, plus preload runs with the reload armed, disarmed and overridden by the mode bit, separates the reload path from plain rollover.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int OFF_W    = 4;
  localparam int SRC_W    = 2;
  localparam int PCTL_W   = 2;
  localparam int NUM_EXT  = 3;

  localparam logic [OFF_W-1:0] OFF_PRE_VAL = 4'd4;
  localparam logic [OFF_W-1:0] OFF_PRE_CTL = 4'd5;
  localparam logic [OFF_W-1:0] OFF_IEN     = 4'd6;
  localparam logic [OFF_W-1:0] OFF_STAT    = 4'd7;
  localparam logic [OFF_W-1:0] OFF_CAP     = 4'd8;
  localparam logic [OFF_W-1:0] OFF_CAP_ST  = 4'd9;

  localparam logic [OFF_W-1:0] GOFF_EN   = 4'd0;
  localparam logic [OFF_W-1:0] GOFF_SRC  = 4'd1;
  localparam logic [OFF_W-1:0] GOFF_MODE = 4'd2;

  typedef enum logic [SRC_W-1:0] {
    SRC_EVERY = 2'd0,
    SRC_EXT0  = 2'd1,
    SRC_EXT1  = 2'd2,
    SRC_EXT2  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/mct_sync.sv
module mct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/mct_rst_sync.sv
module mct_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign srst_n = chain_q[1];
endmodule

// File: rtl/mct_chan_core.sv
module mct_chan_core
  import mct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en_a,
  input  logic [SRC_W-1:0]                 src_sel,
  input  logic                             free_mode,
  input  logic [PCTL_W-1:0]                pre_ctl,
  input  logic [CNT_W-1:0]                 pre_val,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]    match,
  input  logic [NUM_EXT-1:0]               ext_tick,
  input  logic                             cap_req_a,
  output logic [CNT_W-1:0]                 cnt_o,
  output logic                             adv_o,
  output logic                             en_o,
  output logic [CNT_W-1:0]                 cap_val_o,
  output logic                             cap_ack_o,
  output logic [NUM_CMP-1:0]               evt_t_o
);
  logic              en_s, req_s;
  logic              tick_sel, adv, reload_hit;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  cap_q, cap_d;
  logic              ack_q;
  logic [NUM_CMP-1:0] evt_q, evt_d;

  mct_sync #(.W(2)) u_in_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({en_a, cap_req_a}),
    .q    ({en_s, req_s})
  );

  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_EXT0: tick_sel = ext_tick[0];
      SRC_EXT1: tick_sel = ext_tick[1];
      SRC_EXT2: tick_sel = ext_tick[2];
      default:  tick_sel = 1'b1;
    endcase
  end

  always_comb begin
    reload_hit = 1'b0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (pre_ctl == PCTL_W'(k + 1) && cnt_q == match[k]) reload_hit = 1'b1;
    end
  end

  assign adv = en_s & tick_sel;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      if (!free_mode && reload_hit) cnt_d = pre_val;
      else                          cnt_d = cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_evt
    assign evt_d[k] = evt_q[k] ^ (adv && (cnt_d == match[k]));
  end

  assign cap_d = (req_s ^ ack_q) ? cnt_q : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      ack_q <= 1'b0;
      evt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      ack_q <= req_s;
      evt_q <= evt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign adv_o     = adv;
  assign en_o      = en_s;
  assign cap_val_o = cap_q;
  assign cap_ack_o = ack_q;
  assign evt_t_o   = evt_q;
endmodule

// File: rtl/mct_chan_regs.sv
module mct_chan_regs
  import mct_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_hit,
  input  logic [OFF_W-1:0]              off,
  input  logic [31:0]                   wdata,
  input  logic [NUM_CMP-1:0]            evt_t_a,
  input  logic                          cap_ack_a,
  input  logic [CNT_W-1:0]              cap_val,
  output logic [NUM_CMP-1:0][CNT_W-1:0] match_o,
  output logic [CNT_W-1:0]              pre_val_o,
  output logic [PCTL_W-1:0]             pre_ctl_o,
  output logic [NUM_CMP-1:0]            ien_o,
  output logic [NUM_CMP-1:0]            ist_o,
  output logic [NUM_CMP-1:0]            st_set_o,
  output logic                          cap_req_o,
  output logic                          cap_valid_o,
  output logic                          irq_o,
  output logic [31:0]                   rd_data_o
);
  logic [NUM_CMP-1:0]            evt_s, evt_seen_q;
  logic                          ack_s;
  logic [NUM_CMP-1:0][CNT_W-1:0] match_q, match_d;
  logic [CNT_W-1:0]              pre_val_q, pre_val_d;
  logic [PCTL_W-1:0]             pre_ctl_q, pre_ctl_d;
  logic [NUM_CMP-1:0]            ien_q, ien_d;
  logic [NUM_CMP-1:0]            ist_q, ist_d, clr, st_set;
  logic                          req_q, req_d, cap_valid;

  mct_sync #(.W(NUM_CMP + 1)) u_ret_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cap_ack_a, evt_t_a}),
    .q    ({ack_s, evt_s})
  );

  assign st_set    = evt_s ^ evt_seen_q;
  assign cap_valid = (ack_s == req_q);
  assign clr       = (wr_hit && off == OFF_STAT) ? wdata[NUM_CMP-1:0] : '0;

  always_comb begin
    match_d   = match_q;
    pre_val_d = pre_val_q;
    pre_ctl_d = pre_ctl_q;
    ien_d     = ien_q;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (wr_hit && off == OFF_W'(k)) match_d[k] = wdata[CNT_W-1:0];
    end
    if (wr_hit && off == OFF_PRE_VAL) pre_val_d = wdata[CNT_W-1:0];
    if (wr_hit && off == OFF_PRE_CTL) pre_ctl_d = wdata[PCTL_W-1:0];
    if (wr_hit && off == OFF_IEN)     ien_d     = wdata[NUM_CMP-1:0];
    ist_d = st_set | (ist_q & ~clr);
    req_d = req_q ^ (wr_hit && off == OFF_CAP && cap_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q    <= '0;
      pre_val_q  <= '0;
      pre_ctl_q  <= '0;
      ien_q      <= '0;
      ist_q      <= '0;
      req_q      <= 1'b0;
      evt_seen_q <= '0;
    end else begin
      match_q    <= match_d;
      pre_val_q  <= pre_val_d;
      pre_ctl_q  <= pre_ctl_d;
      ien_q      <= ien_d;
      ist_q      <= ist_d;
      req_q      <= req_d;
      evt_seen_q <= evt_s;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (off == OFF_W'(k)) rd_data_o = 32'(match_q[k]);
    end
    case (off)
      OFF_PRE_VAL: rd_data_o = 32'(pre_val_q);
      OFF_PRE_CTL: rd_data_o = 32'(pre_ctl_q);
      OFF_IEN:     rd_data_o = 32'(ien_q);
      OFF_STAT:    rd_data_o = 32'(ist_q);
      OFF_CAP:     rd_data_o = 32'(cap_val);
      OFF_CAP_ST:  rd_data_o = 32'(cap_valid);
      default:     ;
    endcase
  end

  assign match_o     = match_q;
  assign pre_val_o   = pre_val_q;
  assign pre_ctl_o   = pre_ctl_q;
  assign ien_o       = ien_q;
  assign ist_o       = ist_q;
  assign st_set_o    = st_set;
  assign cap_req_o   = req_q;
  assign cap_valid_o = cap_valid;
  assign irq_o       = |(ist_q & ien_q);
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                bus_clk,
  input  logic                cnt_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_EXT-1:0]  ext_tick,
  output logic [NUM_CH-1:0]   irq
);
  localparam int GRP_W = ADDR_W - OFF_W;
  localparam int SRC_BITS = SRC_W * NUM_CH;

  logic bus_rst_n, cnt_rst_n;
  logic [GRP_W-1:0] grp;
  logic [OFF_W-1:0] off;
  logic             glb_hit;

  logic [NUM_CH-1:0]             en_q, en_d, mode_q, mode_d;
  logic [NUM_CH-1:0][SRC_W-1:0]  src_q, src_d;
  logic [31:0]                   rdata_q, rdata_d;

  logic [NUM_CH-1:0][NUM_CMP-1:0][CNT_W-1:0] match_w;
  logic [NUM_CH-1:0][CNT_W-1:0]              pre_val_w, cnt_w, cap_val_w;
  logic [NUM_CH-1:0][PCTL_W-1:0]             pre_ctl_w;
  logic [NUM_CH-1:0][NUM_CMP-1:0]            ien_w, ist_w, st_set_w, evt_t_w;
  logic [NUM_CH-1:0]                         cap_req_w, cap_ack_w, cap_valid_w;
  logic [NUM_CH-1:0]                         adv_w, en_core_w;
  logic [NUM_CH-1:0][31:0]                   ch_rd_w;

  mct_rst_sync u_bus_rst (.clk(bus_clk), .arst_n(rst_n), .srst_n(bus_rst_n));
  mct_rst_sync u_cnt_rst (.clk(cnt_clk), .arst_n(rst_n), .srst_n(cnt_rst_n));

  assign grp     = addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];
  assign glb_hit = (grp == GRP_W'(NUM_CH));

  always_comb begin
    en_d   = en_q;
    src_d  = src_q;
    mode_d = mode_q;
    if (wr_en && glb_hit) begin
      if (off == GOFF_EN)   en_d   = wdata[NUM_CH-1:0];
      if (off == GOFF_SRC)  src_d  = wdata[SRC_BITS-1:0];
      if (off == GOFF_MODE) mode_d = wdata[NUM_CH-1:0];
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      en_q   <= '0;
      src_q  <= '0;
      mode_q <= '0;
    end else begin
      en_q   <= en_d;
      src_q  <= src_d;
      mode_q <= mode_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mct_chan_regs #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_regs (
      .clk        (bus_clk),
      .rst_n      (bus_rst_n),
      .wr_hit     (wr_en && grp == GRP_W'(c)),
      .off        (off),
      .wdata      (wdata),
      .evt_t_a    (evt_t_w[c]),
      .cap_ack_a  (cap_ack_w[c]),
      .cap_val    (cap_val_w[c]),
      .match_o    (match_w[c]),
      .pre_val_o  (pre_val_w[c]),
      .pre_ctl_o  (pre_ctl_w[c]),
      .ien_o      (ien_w[c]),
      .ist_o      (ist_w[c]),
      .st_set_o   (st_set_w[c]),
      .cap_req_o  (cap_req_w[c]),
      .cap_valid_o(cap_valid_w[c]),
      .irq_o      (irq[c]),
      .rd_data_o  (ch_rd_w[c])
    );

    mct_chan_core #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_core (
      .clk      (cnt_clk),
      .rst_n    (cnt_rst_n),
      .en_a     (en_q[c]),
      .src_sel  (src_q[c]),
      .free_mode(mode_q[c]),
      .pre_ctl  (pre_ctl_w[c]),
      .pre_val  (pre_val_w[c]),
      .match    (match_w[c]),
      .ext_tick (ext_tick),
      .cap_req_a(cap_req_w[c]),
      .cnt_o    (cnt_w[c]),
      .adv_o    (adv_w[c]),
      .en_o     (en_core_w[c]),
      .cap_val_o(cap_val_w[c]),
      .cap_ack_o(cap_ack_w[c]),
      .evt_t_o  (evt_t_w[c])
    );
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = '0;
      if (glb_hit) begin
        case (off)
          GOFF_EN:   rdata_d = 32'(en_q);
          GOFF_SRC:  rdata_d = 32'(src_q);
          GOFF_MODE: rdata_d = 32'(mode_q);
          default:   ;
        endcase
      end else begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (grp == GRP_W'(c)) rdata_d = ch_rd_w[c];
        end
      end
    end
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk
  import mct_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input logic                                     bus_clk,
  input logic                                     cnt_clk,
  input logic                                     bus_rst_n,
  input logic                                     cnt_rst_n,
  input logic                                     wr_en,
  input logic [ADDR_W-1:0]                        addr,
  input logic [31:0]                              wdata,
  input logic [NUM_CH-1:0]                        mode_q,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]           ist_w,
  input logic [NUM_CH-1:0][NUM_CMP-1:0]           st_set_w,
  input logic [NUM_CH-1:0]                        cap_valid_w,
  input logic [NUM_CH-1:0][CNT_W-1:0]             cap_val_w,
  input logic [NUM_CH-1:0][CNT_W-1:0]             cnt_w,
  input logic [NUM_CH-1:0]                        adv_w,
  input logic [NUM_CH-1:0]                        en_core_w
);
  localparam int GRP_W = ADDR_W - OFF_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic clr_hit, cap_hit;
    assign clr_hit = wr_en && addr == {GRP_W'(c), OFF_STAT};
    assign cap_hit = wr_en && addr == {GRP_W'(c), OFF_CAP};

    AST_HOLD_WHEN_OFF: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      !en_core_w[c] |=> $stable(cnt_w[c])); // R3

    AST_WRAP_TO_ZERO: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      (mode_q[c] && adv_w[c] && cnt_w[c] == {CNT_W{1'b1}}) |=> cnt_w[c] == '0); // R6

    AST_CAP_INVALIDATE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (cap_hit && cap_valid_w[c]) |=> !cap_valid_w[c]); // R4

    AST_CAP_STABLE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (cap_valid_w[c] && $past(cap_valid_w[c])) |-> $stable(cap_val_w[c])); // R4

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_k
      AST_MATCH_SETS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        st_set_w[c][k] |=> ist_w[c][k]); // R7

      AST_STATUS_STICKY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ist_w[c][k] && !(clr_hit && wdata[k])) |=> ist_w[c][k]); // R8

      AST_W1C_CLEARS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (clr_hit && wdata[k] && !st_set_w[c][k]) |=> !ist_w[c][k]); // R9
    end
  end
endmodule

bind mct_timer mct_timer_chk #(
  .NUM_CH(NUM_CH), .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .bus_clk    (bus_clk),
  .cnt_clk    (cnt_clk),
  .bus_rst_n  (bus_rst_n),
  .cnt_rst_n  (cnt_rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .mode_q     (mode_q),
  .ist_w      (ist_w),
  .st_set_w   (st_set_w),
  .cap_valid_w(cap_valid_w),
  .cap_val_w  (cap_val_w),
  .cnt_w      (cnt_w),
  .adv_w      (adv_w),
  .en_core_w  (en_core_w)
);

// File: tb/sim_mct_timer.sv
module sim_mct_timer;
  localparam int NCH = 3, NCMP = 3, CW = 8, AW = 8;

  logic bus_clk, cnt_clk, rst_n, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata;
  logic [2:0] ext_tick;
  logic [NCH-1:0] irq;

  int errors = 0, checks = 0;
  bit done = 0;

  int m[NCH], sel_m[NCH], pctl_m[NCH], pre_m[NCH];
  int match_m[NCH][NCMP];
  bit en_m[NCH], free_m[NCH];
  bit [2:0] st_m[NCH];

  mct_timer #(.NUM_CH(NCH), .NUM_CMP(NCMP), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .bus_clk(bus_clk), .cnt_clk(cnt_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .irq(irq));

  initial begin bus_clk = 0; forever #5 bus_clk = ~bus_clk; end
  initial begin cnt_clk = 0; #3; forever #5 cnt_clk = ~cnt_clk; end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge bus_clk); wr_en = 1; addr = AW'(a); wdata = 32'(d);
    @(negedge bus_clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge bus_clk); rd_en = 1; addr = AW'(a);
    @(negedge bus_clk); rd_en = 0; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge bus_clk);
  endtask

  function automatic int step(int c, int v);
    if (!free_m[c] && pctl_m[c] != 0 && v == match_m[c][pctl_m[c]-1]) return pre_m[c];
    return (v + 1) % 256;
  endfunction

  task automatic pulse(int src, int n);
    repeat (n) begin
      @(negedge cnt_clk); ext_tick[src-1] = 1'b1;
      @(negedge cnt_clk); ext_tick = '0;
      for (int c = 0; c < NCH; c++) begin
        if (en_m[c] && sel_m[c] == src) begin
          m[c] = step(c, m[c]);
          for (int k = 0; k < NCMP; k++) if (m[c] == match_m[c][k]) st_m[c][k] = 1'b1;
        end
      end
    end
    idle(6);
  endtask

  task automatic capture(int c, output logic [31:0] v);
    logic [31:0] s;
    wr(c*16 + 8, 0);
    for (int i = 0; i < 40; i++) begin
      rd(c*16 + 9, s);
      if (s[0]) break;
    end
    rd(c*16 + 8, v);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; ext_tick = '0;
    for (int c = 0; c < NCH; c++) begin
      m[c] = 0; sel_m[c] = 0; pctl_m[c] = 0; pre_m[c] = 0; en_m[c] = 0; free_m[c] = 0; st_m[c] = 0;
      for (int k = 0; k < NCMP; k++) match_m[c][k] = 0;
    end
    #25 rst_n = 1;
    idle(5);

    // R1 reset state
    rd(8'h30, v); chk(v == 0, "R1 enable reset", v, 0);
    rd(8'h07, v); chk(v == 0, "R1 status reset", v, 0);
    rd(8'h11, v); chk(v == 0, "R1 match reset", v, 0);
    rd(8'h29, v); chk(v == 1, "R1 capture status reset", v, 1);
    rd(8'h18, v); chk(v == 0, "R1 capture value reset", v, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
    rd(8'h0C, v); chk(v == 0, "R12 unmapped offset", v, 0);

    // R5 / R12 global configuration
    wr(8'h31, 32'h19); sel_m[0] = 1; sel_m[1] = 2; sel_m[2] = 1;
    rd(8'h31, v); chk(v == 32'h19, "R5 source field readback", v, 32'h19);
    wr(8'h32, 7); for (int c = 0; c < NCH; c++) free_m[c] = 1;
    wr(8'h30, 7); idle(5); for (int c = 0; c < NCH; c++) en_m[c] = 1;
    rd(8'h30, v); chk(v == 7, "R2 enable readback", v, 7);

    // R2 sweep of burst lengths
    for (int n = 1; n <= 6; n++) begin
      pulse(1, n);
      capture(0, v); chk(v == 32'(m[0]), "R2 count ch0", v, m[0]);
      capture(2, v); chk(v == 32'(m[2]), "R2 count ch2", v, m[2]);
    end

    // R5 unselected source
    pulse(2, 4);
    capture(0, v); chk(v == 32'(m[0]), "R5 ch0 ignores ext_tick[1]", v, m[0]);
    capture(1, v); chk(v == 4, "R5 ch1 counts ext_tick[1]", v, 4);

    // R3 disabled channel holds
    wr(8'h30, 6); idle(5); en_m[0] = 0;
    pulse(1, 5);
    capture(0, v); chk(v == 32'(m[0]), "R3 ch0 frozen", v, m[0]);
    capture(2, v); chk(v == 32'(m[2]), "R3 ch2 still counts", v, m[2]);
    wr(8'h30, 7); idle(5); en_m[0] = 1;

    // R4 capture handshake status
    wr(8'h08, 0);
    rd(8'h09, v); chk(v[0] == 0, "R4 capture pending", v, 0);
    idle(12);
    rd(8'h09, v); chk(v[0] == 1, "R4 capture settled", v, 1);
    rd(8'h08, v); chk(v == 32'(m[0]), "R4 capture value", v, m[0]);

    // R7 R8 R10 tick-by-tick match walk on ch2
    wr(8'h07, 7); wr(8'h17, 7); wr(8'h27, 7);
    for (int c = 0; c < NCH; c++) st_m[c] = 0;
    match_m[2][0] = (m[2] + 3) % 256; match_m[2][1] = (m[2] + 10) % 256; match_m[2][2] = (m[2] + 200) % 256;
    for (int k = 0; k < NCMP; k++) wr(8'h20 + k, match_m[2][k]);
    wr(8'h26, 1);
    for (int i = 1; i <= 12; i++) begin
      pulse(1, 1);
      rd(8'h27, v); chk(v == 32'(st_m[2]), "R7 R8 status walk", v, st_m[2]);
      chk(irq[2] == st_m[2][0], "R10 irq follows enabled status", irq[2], st_m[2][0]);
    end

    // R9 write-one-to-clear
    wr(8'h27, 1); st_m[2][0] = 0;
    rd(8'h27, v); chk(v == 32'(st_m[2]), "R9 clear bit0 only", v, st_m[2]);
    chk(irq[2] == 0, "R10 irq low after clear", irq[2], 0);
    wr(8'h26, 2); @(negedge bus_clk);
    chk(irq[2] == 1, "R10 irq via enable bit1", irq[2], 1);
    wr(8'h27, 7); st_m[2] = 0;
    rd(8'h27, v); chk(v == 0, "R9 clear all", v, 0);
    chk(irq[2] == 0, "R10 irq low all clear", irq[2], 0);

    // R6 wrap on ch0 (match registers at zero also fire R7)
    wr(8'h07, 7); st_m[0] = 0;
    pulse(1, 256 - m[0]);
    capture(0, v); chk(v == 0, "R6 wrap to zero", v, 0);
    rd(8'h07, v); chk(v == 7, "R7 zero targets hit at wrap", v, 7);
    pulse(1, 3);
    capture(0, v); chk(v == 32'(m[0]), "R6 count after wrap", v, m[0]);

    // R11 preload mode on ch1
    wr(8'h14, 5); pre_m[1] = 5;
    wr(8'h11, 9); match_m[1][1] = 9;
    wr(8'h15, 2); pctl_m[1] = 2;
    wr(8'h32, 5); free_m[1] = 0;
    pulse(2, 20);
    capture(1, v); chk(v == 32'(m[1]), "R11 preload reload", v, m[1]);
    wr(8'h32, 7); free_m[1] = 1;
    pulse(2, 10);
    capture(1, v); chk(v == 32'(m[1]), "R11 mode bit overrides reload", v, m[1]);
    wr(8'h32, 5); free_m[1] = 0; wr(8'h15, 0); pctl_m[1] = 0;
    pulse(2, 7);
    capture(1, v); chk(v == 32'(m[1]), "R11 control zero no reload", v, m[1]);

    // R5 source 0 counts every counter clock
    wr(8'h31, 32'h11); idle(5);
    capture(1, v); idle(20); capture(1, v2);
    chk(((v2 - v) & 32'hFF) >= 20, "R5 source 0 free count", (v2 - v) & 32'hFF, 20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule